// File: doc/BRIEF.md
# Carry Select Adder with Increment-Based Upper Path

This block adds two unsigned operands and a carry-in, producing a sum of the operand width and a carry-out. The operands are cut into equal slices of four bits. Every slice above the lowest adds its two input slices with a ripple chain whose carry-in is held at zero. The slice does not build a second ripple chain for the case where a carry arrives. It instead passes its zero-carry result, carry bit included, through an incrementer that adds one. The real carry arriving from the slice below then chooses between the plain result and the incremented one.

The lowest slice is a plain ripple adder fed straight by the external carry-in. The carry chosen by each slice drives the selection of the slice above it, and the carry chosen by the top slice is the carry-out. The adder works at 8, 16 and 32 bits. A parameter places a register stage on the outputs when timing needs one. Without that stage the block is purely combinational.

Top module: `csla_adder`

## Requirements
- R1: `sum_out` equals the low WIDTH bits of `a_in + b_in + c_in`, taken as unsigned numbers.
- R2: `c_out` equals bit WIDTH of `a_in + b_in + c_in`, which is the carry out of the full addition.
- R3: The external carry-in enters only the lowest slice, and it must travel through every slice. With `a_in` all ones, `b_in` zero and `c_in` 1, the result is `sum_out` 0 and `c_out` 1.
- R4: In every slice above the lowest, the incremented result (carry bit plus sum bits, GRP_W+1 bits wide) equals the zero-carry result plus one.
- R5: In every slice above the lowest, the selected sum and carry equal the zero-carry result when the incoming carry is 0, and the incremented result when it is 1.
- R6: The block builds with WIDTH of 8, 16 and 32. A WIDTH that is not a multiple of GRP_W is rejected at elaboration.
- R7: With OUT_REG = 1, `sum_out` and `c_out` show the result for the inputs sampled at the previous rising edge of `clk`. While `rst_n` is low, both outputs are 0.
- R8: With OUT_REG = 0, `sum_out` and `c_out` follow the inputs with no clock edge, and `clk` and `rst_n` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| c_in | input | 1 | Carry into the lowest slice |
| sum_out | output | WIDTH | Sum, low WIDTH bits |
| c_out | output | 1 | Carry out of the top slice |

## Verification
The 8-bit combinational build is swept over every operand pair with both carry-in values. This catches an incrementer bit with a wrong AND term, which would give wrong sums only for particular low patterns in a slice. It also catches a multiplexer select wired to the wrong carry, which would break every sum that crosses a slice boundary. The all-ones plus carry-in case drives a carry through every slice. If the incrementer dropped its extra carry bit, that case would lose the carry-out. The registered 32-bit build is checked one edge after each input and during reset. A missing or doubled register stage would show results a cycle early or late. The 16-bit build gets corner patterns and random operands.

// File: rtl/csla_pkg.sv
package csla_pkg;

  // Sum bit of one full adder cell.
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // Carry bit of one full adder cell (majority of the three inputs).
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

endpackage

// File: rtl/csla_ripple.sv
module csla_ripple #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         co
);
  import csla_pkg::*;

  logic [N:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < N; i++) begin : g_cell
    assign s[i]       = fa_sum(a[i], b[i], chain[i]);
    assign chain[i+1] = fa_carry(a[i], b[i], chain[i]);
  end

  assign co = chain[N];
endmodule

// File: rtl/csla_bec.sv
module csla_bec #(
  parameter int N = 4
) (
  input  logic [N:0] v,
  output logic [N:0] x
);
  // Running AND of all bits below position i.
  logic [N:0] all_low;
  assign all_low[0] = 1'b1;
  assign x[0]       = ~v[0];

  for (genvar i = 1; i <= N; i++) begin : g_bit
    assign all_low[i] = all_low[i-1] & v[i-1];
    assign x[i]       = v[i] ^ all_low[i];
  end
endmodule

// File: rtl/csla_group.sv
module csla_group #(
  parameter int N     = 4,
  parameter bit FIRST = 1'b0
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sel_c,
  output logic [N-1:0] s,
  output logic         co
);
  if (FIRST) begin : g_lsb
    csla_ripple #(.N(N)) u_rca (.a(a), .b(b), .ci(sel_c), .s(s), .co(co));
  end else begin : g_sel
    logic [N:0] plain_res;  // {carry, sum} with carry-in 0
    logic [N:0] inc_res;    // {carry, sum} with carry-in 1

    csla_ripple #(.N(N)) u_rca (
      .a(a), .b(b), .ci(1'b0), .s(plain_res[N-1:0]), .co(plain_res[N])
    );
    csla_bec #(.N(N)) u_bec (.v(plain_res), .x(inc_res));

    assign {co, s} = sel_c ? inc_res : plain_res;

    always_comb begin
      // R4
      bec_plus_one_chk: assert (inc_res == plain_res + 1'b1);
      // R5
      select_chk: assert ({co, s} == (sel_c ? ({1'b0, a} + {1'b0, b} + 1'b1)
                                            : ({1'b0, a} + {1'b0, b})));
    end
  end
endmodule

// File: rtl/csla_adder.sv
module csla_adder #(
  parameter int WIDTH   = 16,
  parameter int GRP_W   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             c_out
);
  localparam int NGRP = WIDTH / GRP_W;

  // R6
  if ((WIDTH % GRP_W) != 0 || WIDTH < GRP_W) begin : g_bad_width
    $error("csla_adder: WIDTH must be a positive multiple of GRP_W");
  end

  logic [NGRP:0]    grp_carry;  // carry selected by each slice
  logic [WIDTH-1:0] sum_comb;
  logic             cout_comb;

  assign grp_carry[0] = c_in;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    csla_group #(.N(GRP_W), .FIRST(g == 0)) u_grp (
      .a    (a_in[g*GRP_W +: GRP_W]),
      .b    (b_in[g*GRP_W +: GRP_W]),
      .sel_c(grp_carry[g]),
      .s    (sum_comb[g*GRP_W +: GRP_W]),
      .co   (grp_carry[g+1])
    );
  end

  assign cout_comb = grp_carry[NGRP];

  always_comb begin
    // R1 R2
    full_sum_chk: assert ({cout_comb, sum_comb} ==
                          {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in});
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_out <= '0;
        c_out   <= 1'b0;
      end else begin
        sum_out <= sum_comb;
        c_out   <= cout_comb;
      end
    end

    // R7
    reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ({c_out, sum_out} ==
        $past({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in})));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (sum_out == '0 && c_out == 1'b0));
  end else begin : g_comb
    assign sum_out = sum_comb;
    assign c_out   = cout_comb;
  end
endmodule

// File: tb/tb_csla_adder.sv
module tb_csla_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Registered 32-bit build
  logic [31:0] a32, b32, s32;
  logic        c32, co32;
  csla_adder #(.WIDTH(32), .GRP_W(4), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a32), .b_in(b32), .c_in(c32),
    .sum_out(s32), .c_out(co32));

  // Combinational 8-bit build
  logic [7:0] a8, b8, s8;
  logic       c8, co8;
  csla_adder #(.WIDTH(8), .GRP_W(4), .OUT_REG(1'b0)) dut8 (
    .clk(clk), .rst_n(rst_n), .a_in(a8), .b_in(b8), .c_in(c8),
    .sum_out(s8), .c_out(co8));

  // Combinational 16-bit build
  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  csla_adder #(.WIDTH(16), .GRP_W(4), .OUT_REG(1'b0)) dut16 (
    .clk(clk), .rst_n(rst_n), .a_in(a16), .b_in(b16), .c_in(c16),
    .sum_out(s16), .c_out(co16));

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  function automatic logic [32:0] ref_add(input logic [31:0] x, input logic [31:0] y,
                                          input logic ci, input int w);
    logic [32:0] r;
    logic [32:0] mask;
    r = {1'b0, x} + {1'b0, y} + 33'(ci);
    mask = (33'd1 << w) - 33'd1;
    return {r[w], 32'd0} >> (32 - w) | (r & mask);
  endfunction

  task automatic chk16(input logic [15:0] x, input logic [15:0] y, input logic ci, input string req);
    a16 = x; b16 = y; c16 = ci;
    #1;
    check(req, {16'd0, co16, s16}, ref_add({16'd0, x}, {16'd0, y}, ci, 16));
  endtask

  task automatic chk32(input logic [31:0] x, input logic [31:0] y, input logic ci, input string req);
    @(negedge clk);
    a32 = x; b32 = y; c32 = ci;
    @(negedge clk);
    check(req, {co32, s32}, ref_add(x, y, ci, 32));
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    a32 = 32'hFFFF_FFFF; b32 = 32'h1; c32 = 1'b1;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    repeat (3) @(negedge clk);
    // R7: reset state on the registered build
    check("R7 reset", {co32, s32}, 33'd0);

    // R8: combinational builds answer during reset, no edge needed
    a8 = 8'h7F; b8 = 8'h01; c8 = 1'b1; #1;
    check("R8 comb in reset", {24'd0, co8, s8}, 33'h81);

    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R4 R5 R6: exhaustive 8-bit sweep
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int ci = 0; ci < 2; ci++) begin
          a8 = 8'(x); b8 = 8'(y); c8 = 1'(ci);
          #1;
          check("R1 R2 R5 8-bit sweep", {24'd0, co8, s8}, ref_add(32'(x), 32'(y), 1'(ci), 8));
        end
      end
    end

    // R3: carry through every slice
    a8 = 8'hFF; b8 = 8'h00; c8 = 1'b1; #1;
    check("R3 8-bit propagate", {24'd0, co8, s8}, 33'h100);
    chk16(16'hFFFF, 16'h0000, 1'b1, "R3 16-bit propagate");
    chk16(16'h0000, 16'h0000, 1'b0, "R1 16-bit zeros");
    chk16(16'hFFFF, 16'hFFFF, 1'b1, "R2 16-bit max");
    chk16(16'hAAAA, 16'h5555, 1'b1, "R4 16-bit alternating");
    chk16(16'h0FF0, 16'h0010, 1'b0, "R5 16-bit mid carry");
    for (int i = 0; i < 3000; i++) begin
      chk16(16'($urandom), 16'($urandom), 1'($urandom), "R6 16-bit random");
    end

    // R7: registered build, one edge of latency
    chk32(32'hFFFF_FFFF, 32'h0, 1'b1, "R3 32-bit propagate");
    chk32(32'h0, 32'h0, 1'b0, "R7 32-bit zeros");
    chk32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2 32-bit max");
    chk32(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 32-bit top carry");
    for (int i = 0; i < 2000; i++) begin
      chk32($urandom, $urandom, 1'($urandom), "R6 32-bit random");
    end

    // R7: output holds the previous edge's result, not the new inputs, before the edge
    @(negedge clk);
    a32 = 32'h1234_5678; b32 = 32'h1111_1111; c32 = 1'b0;
    @(negedge clk);
    a32 = 32'h0; b32 = 32'h0; c32 = 1'b0;
    #1;
    check("R7 latency", {co32, s32}, 33'h0_2345_6789);

    // R7: asynchronous reset clears outputs
    rst_n = 1'b0;
    #1;
    check("R7 async clear", {co32, s32}, 33'd0);

    done = 1'b1;
    report();
  end
endmodule